// File: doc/BRIEF.md
# Binary/BCD Calendar Counter with Alarm Compare

This block keeps the time of day and the calendar: seconds, minutes, hours, day of the week, day of the month, month and a two-digit year. Each pulse on the one-second update input advances the count by one second. Carries ripple through hours, days, months and years, with month lengths and leap years applied. Every byte is held either in plain binary or in BCD, and the hours byte is in either 24-hour form or 12-hour form with a PM flag. The encoding and the hours format are picked at run time by two control inputs. An optional daylight-saving rule moves the clock forward one hour on the first Sunday of April. On the last Sunday of October it moves the clock back one hour, once.

Two copies of the time are kept. The live copy counts and drives the alarm compare. The readable copy is what the register port returns. While the hold input is high, the readable copy is frozen and takes writes, and the live copy goes on counting. When hold drops, the live copy is reloaded from the readable copy, so counting resumes from what software wrote. Three alarm bytes for seconds, minutes and hours are compared with the live time on every update. The alarm output pulses for one cycle when all three agree. A byte with its two top bits set matches any value.

The sequencer has four states. IDLE waits. It goes to RELOAD when a hold release is pending, since a release takes priority over a tick, and otherwise it goes to STEP when an update tick is pending. STEP loads the next time into the live copy and always goes on to PUBLISH. PUBLISH raises the alarm pulse on a match, copies live into readable when hold is low, and returns to IDLE. RELOAD loads the live copy from the readable copy and returns to IDLE. A tick or a hold release that arrives outside IDLE is latched until IDLE is reached.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the readable time is 00:00:00, with day of week 0x01, date 0x01, month 0x01 and year 0x00, all alarm bytes 0x00, and alarm_hit low.
- R2: Each update tick advances the time by exactly one second. Seconds and minutes wrap 59 to 0 with a carry. With bin_mode=1 the bytes are binary (59 = 0x3B). With bin_mode=0 they are BCD (59 = 0x59).
- R3: With h24_mode=1 the hours count 0 to 23, and 23:59:59 rolls to 00:00:00 with a day carry.
- R4: With h24_mode=0 the hours count 1 to 12 and bit 7 of the hours byte is PM. 11:59:59 rolls to 12:00:00 and flips PM (12 PM is 0x92 in BCD, 0x8C in binary). 12:59:59 rolls to 1:00:00 and keeps PM. The day advances only on the PM-to-AM change.
- R5: Day of week counts 1..7 and wraps 7 to 1. The date wraps at the month length: 30 days for months 4, 6, 9 and 11, 29 for February when the year is divisible by 4 and 28 otherwise, and 31 for the rest. December wraps to January with a year carry, and year 99 wraps to 0.
- R6: While set_hold=1 the readable time does not change on ticks, but the live copy keeps counting and keeps driving the alarm. Time writes are accepted only while set_hold=1, and a time write with set_hold=0 leaves the readable value unchanged.
- R7: When set_hold falls, the live copy is loaded from the readable copy and the next tick counts on from the written values. The once-only daylight-saving marker is cleared.
- R8: With dst_en=1, a Sunday (day of week 1) in April with date 1..7 goes from 1:59:59 AM straight to 3:00:00 AM.
- R9: With dst_en=1, a Sunday in October with date 25..31 goes from 1:59:59 AM back to 1:00:00 AM only the first time that day. The second pass continues to 2:00:00.
- R10: Alarm bytes are at addresses 1 (seconds), 3 (minutes) and 5 (hours) and can be written at any time. alarm_hit is high for exactly one cycle on an update whose new live seconds, minutes and hours bytes all equal the alarm bytes.
- R11: An alarm byte whose bits 7:6 are 11 (0xC0..0xFF) matches any value, so three such bytes give a pulse on every update.
- R12: With a tick sampled at clock edge E, alarm_hit is valid between E+1 and E+2, and the readable copy holds the new time from E+2.
- R13: The address map is 0 seconds, 2 minutes, 4 hours, 6 day of week, 7 date, 8 month and 9 year. Addresses 10 to 15 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_1hz | input | 1 | One-cycle update pulse, once per second |
| set_hold | input | 1 | Freeze the readable copy and allow time writes |
| bin_mode | input | 1 | 1 = binary, 0 = BCD |
| h24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| dst_en | input | 1 | Enable the daylight-saving jumps |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data from the readable copy (combinational) |
| alarm_hit | output | 1 | One-cycle alarm match pulse |

## Verification
A tick driven at a falling edge is sampled at the next rising edge E. The alarm pulse is due during the cycle after E+1, and the new time is readable after E+2. The bench samples alarm_hit at the falling edge between those two edges and reads the registers only after the second one. A hold release needs two rising edges before the reload has taken effect, so the bench waits two falling edges before it issues the next tick. Reads use the combinational port while the block is idle, so no update can overlap them.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

    localparam int BYTE_W = 8;
    localparam int VAL_W  = 7;
    localparam int N_ALM  = 3;

    localparam int ADR_SEC  = 0;
    localparam int ADR_ASEC = 1;
    localparam int ADR_MIN  = 2;
    localparam int ADR_AMIN = 3;
    localparam int ADR_HOUR = 4;
    localparam int ADR_AHR  = 5;
    localparam int ADR_DOW  = 6;
    localparam int ADR_DATE = 7;
    localparam int ADR_MON  = 8;
    localparam int ADR_YEAR = 9;

    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] dow;
        logic [BYTE_W-1:0] date;
        logic [BYTE_W-1:0] mon;
        logic [BYTE_W-1:0] year;
    } cal_t;

    typedef enum logic [1:0] {S_IDLE, S_STEP, S_PUBLISH, S_RELOAD} seq_state_t;

    localparam cal_t CAL_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00, dow: 8'h01,
                                   date: 8'h01, mon: 8'h01, year: 8'h00};

    function automatic logic [VAL_W-1:0] dec_byte(input logic [BYTE_W-1:0] b, input logic bin);
        logic [VAL_W-1:0] hi;
        logic [VAL_W-1:0] lo;
        hi = VAL_W'(b[7:4]);
        lo = VAL_W'(b[3:0]);
        return bin ? b[VAL_W-1:0] : (hi * 7'd10 + lo);
    endfunction

    function automatic logic [BYTE_W-1:0] enc_byte(input logic [VAL_W-1:0] v, input logic bin);
        logic [VAL_W-1:0] tens;
        logic [VAL_W-1:0] ones;
        tens = v / 7'd10;
        ones = v % 7'd10;
        return bin ? {1'b0, v} : {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [VAL_W-1:0] month_len(input logic [VAL_W-1:0] mon,
                                                   input logic [VAL_W-1:0] yr);
        logic [VAL_W-1:0] len;
        if (mon == 7'd2)
            len = (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
        else if (mon == 7'd4 || mon == 7'd6 || mon == 7'd9 || mon == 7'd11)
            len = 7'd30;
        else
            len = 7'd31;
        return len;
    endfunction

endpackage

// File: rtl/rtc_time_step.sv
`timescale 1ns/1ps
module rtc_time_step
    import rtc_cal_pkg::*;
(
    input  cal_t cur,
    input  logic bin_mode,
    input  logic h24_mode,
    input  logic dst_en,
    input  logic fb_done,
    output cal_t nxt,
    output logic fb_fire,
    output logic day_roll
);

    logic [VAL_W-1:0] s, m, h, dw, dt, mo, yr;
    logic [VAL_W-1:0] ns, nm, nh, ndw, ndt, nmo, nyr;
    logic             pm, npm, am_one, sec_wrap, min_wrap, spring, fall;
    logic [BYTE_W-1:0] hour_enc;

    always_comb begin
        s  = dec_byte(cur.sec, bin_mode);
        m  = dec_byte(cur.min, bin_mode);
        h  = h24_mode ? dec_byte(cur.hour, bin_mode) : dec_byte({1'b0, cur.hour[6:0]}, bin_mode);
        pm = h24_mode ? 1'b0 : cur.hour[7];
        dw = dec_byte(cur.dow, bin_mode);
        dt = dec_byte(cur.date, bin_mode);
        mo = dec_byte(cur.mon, bin_mode);
        yr = dec_byte(cur.year, bin_mode);

        sec_wrap = (s == 7'd59);
        min_wrap = sec_wrap && (m == 7'd59);
        am_one   = (h == 7'd1) && (h24_mode || !pm);
        spring   = dst_en && min_wrap && am_one && (dw == 7'd1) && (mo == 7'd4) && (dt <= 7'd7);
        fall     = dst_en && min_wrap && am_one && (dw == 7'd1) && (mo == 7'd10) &&
                   (dt >= 7'd25) && !fb_done;

        ns = s; nm = m; nh = h; npm = pm;
        day_roll = 1'b0;
        fb_fire  = 1'b0;

        if (!sec_wrap) begin
            ns = s + 7'd1;
        end else begin
            ns = 7'd0;
            if (m != 7'd59) begin
                nm = m + 7'd1;
            end else begin
                nm = 7'd0;
                if (spring) begin
                    nh = 7'd3;
                end else if (fall) begin
                    nh = 7'd1;
                    fb_fire = 1'b1;
                end else if (h24_mode) begin
                    if (h == 7'd23) begin
                        nh = 7'd0;
                        day_roll = 1'b1;
                    end else begin
                        nh = h + 7'd1;
                    end
                end else begin
                    if (h == 7'd11) begin
                        nh = 7'd12;
                        npm = !pm;
                        day_roll = pm;
                    end else if (h == 7'd12) begin
                        nh = 7'd1;
                    end else begin
                        nh = h + 7'd1;
                    end
                end
            end
        end

        ndw = dw; ndt = dt; nmo = mo; nyr = yr;
        if (day_roll) begin
            ndw = (dw >= 7'd7) ? 7'd1 : dw + 7'd1;
            if (dt >= month_len(mo, yr)) begin
                ndt = 7'd1;
                if (mo >= 7'd12) begin
                    nmo = 7'd1;
                    nyr = (yr >= 7'd99) ? 7'd0 : yr + 7'd1;
                end else begin
                    nmo = mo + 7'd1;
                end
            end else begin
                ndt = dt + 7'd1;
            end
        end

        hour_enc = enc_byte(nh, bin_mode);
        nxt.sec  = enc_byte(ns, bin_mode);
        nxt.min  = enc_byte(nm, bin_mode);
        nxt.hour = h24_mode ? hour_enc : {npm, hour_enc[6:0]};
        nxt.dow  = enc_byte(ndw, bin_mode);
        nxt.date = enc_byte(ndt, bin_mode);
        nxt.mon  = enc_byte(nmo, bin_mode);
        nxt.year = enc_byte(nyr, bin_mode);
    end

endmodule

// File: rtl/rtc_alarm_match.sv
`timescale 1ns/1ps
module rtc_alarm_match
    import rtc_cal_pkg::*;
#(
    parameter int FIELDS = N_ALM
) (
    input  logic [FIELDS-1:0][BYTE_W-1:0] now_v,
    input  logic [FIELDS-1:0][BYTE_W-1:0] alm_v,
    output logic                          hit
);

    logic [FIELDS-1:0] field_ok;

    for (genvar i = 0; i < FIELDS; i++) begin : g_field
        assign field_ok[i] = (alm_v[i][7:6] == 2'b11) || (alm_v[i] == now_v[i]);
    end

    assign hit = &field_ok;

endmodule

// File: rtl/rtc_calendar_core.sv
`timescale 1ns/1ps
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              set_hold,
    input  logic              bin_mode,
    input  logic              h24_mode,
    input  logic              dst_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic              alarm_hit
);

    seq_state_t state_q, state_d;
    cal_t       live_q, user_q, live_nxt;
    logic [N_ALM-1:0][BYTE_W-1:0] alm_q;
    logic [N_ALM-1:0][BYTE_W-1:0] now_v;
    logic set_q, tick_pend_q, reload_pend_q, fb_done_q;
    logic set_fall, reload_need, step_need, fb_fire, day_roll, alm_match;

    assign set_fall    = set_q && !set_hold;
    assign reload_need = reload_pend_q || set_fall;
    assign step_need   = tick_pend_q || tick_1hz;
    assign now_v       = {live_q.hour, live_q.min, live_q.sec};

    rtc_time_step u_step (
        .cur      (live_q),
        .bin_mode (bin_mode),
        .h24_mode (h24_mode),
        .dst_en   (dst_en),
        .fb_done  (fb_done_q),
        .nxt      (live_nxt),
        .fb_fire  (fb_fire),
        .day_roll (day_roll)
    );

    rtc_alarm_match #(.FIELDS(N_ALM)) u_alarm (
        .now_v (now_v),
        .alm_v (alm_q),
        .hit   (alm_match)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (reload_need)    state_d = S_RELOAD;
                else if (step_need) state_d = S_STEP;
            end
            S_STEP:    state_d = S_PUBLISH;
            S_PUBLISH: state_d = S_IDLE;
            S_RELOAD:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register and pending requests
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= S_IDLE;
            set_q         <= 1'b0;
            tick_pend_q   <= 1'b0;
            reload_pend_q <= 1'b0;
        end else begin
            state_q       <= state_d;
            set_q         <= set_hold;
            reload_pend_q <= (state_q != S_IDLE) && reload_need;
            tick_pend_q   <= (state_q == S_IDLE && !reload_need) ? 1'b0 : step_need;
        end
    end

    // time copies and alarm bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q    <= CAL_RESET;
            user_q    <= CAL_RESET;
            alm_q     <= '0;
            fb_done_q <= 1'b0;
        end else begin
            if (state_q == S_STEP) begin
                live_q <= live_nxt;
                if (day_roll)     fb_done_q <= 1'b0;
                else if (fb_fire) fb_done_q <= 1'b1;
            end else if (state_q == S_RELOAD) begin
                live_q    <= user_q;
                fb_done_q <= 1'b0;
            end

            if (state_q == S_PUBLISH && !set_hold) begin
                user_q <= live_q;
            end else if (wr_en && set_hold) begin
                case (reg_addr)
                    ADDR_W'(ADR_SEC):  user_q.sec  <= wr_data;
                    ADDR_W'(ADR_MIN):  user_q.min  <= wr_data;
                    ADDR_W'(ADR_HOUR): user_q.hour <= wr_data;
                    ADDR_W'(ADR_DOW):  user_q.dow  <= wr_data;
                    ADDR_W'(ADR_DATE): user_q.date <= wr_data;
                    ADDR_W'(ADR_MON):  user_q.mon  <= wr_data;
                    ADDR_W'(ADR_YEAR): user_q.year <= wr_data;
                    default: ;
                endcase
            end

            if (wr_en) begin
                case (reg_addr)
                    ADDR_W'(ADR_ASEC): alm_q[0] <= wr_data;
                    ADDR_W'(ADR_AMIN): alm_q[1] <= wr_data;
                    ADDR_W'(ADR_AHR):  alm_q[2] <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        alarm_hit = (state_q == S_PUBLISH) && alm_match;
        unique case (reg_addr)
            ADDR_W'(ADR_SEC):  rd_data = user_q.sec;
            ADDR_W'(ADR_ASEC): rd_data = alm_q[0];
            ADDR_W'(ADR_MIN):  rd_data = user_q.min;
            ADDR_W'(ADR_AMIN): rd_data = alm_q[1];
            ADDR_W'(ADR_HOUR): rd_data = user_q.hour;
            ADDR_W'(ADR_AHR):  rd_data = alm_q[2];
            ADDR_W'(ADR_DOW):  rd_data = user_q.dow;
            ADDR_W'(ADR_DATE): rd_data = user_q.date;
            ADDR_W'(ADR_MON):  rd_data = user_q.mon;
            ADDR_W'(ADR_YEAR): rd_data = user_q.year;
            default:           rd_data = 8'h00;
        endcase
    end

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> !alarm_hit);

    a_r12_step_then_publish: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STEP) |=> (state_q == S_PUBLISH));

    a_r12_publish_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PUBLISH && !set_hold) |=> (user_q == $past(live_q)));

    a_r6_frozen_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (set_hold && !wr_en) |=> $stable(user_q));

    a_r7_reload_from_user: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RELOAD) |=> (live_q == $past(user_q)));

endmodule

// File: tb/sim_rtc_calendar_core.sv
`timescale 1ns/1ps
module sim_rtc_calendar_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       set_hold = 1'b0;
    logic       bin_mode = 1'b0;
    logic       h24_mode = 1'b1;
    logic       dst_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       alarm_hit;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state (live copy), binary values
    int ms, mm, mh, mpm, mdow, mdate, mmon, myr;
    int mbin, m24, mdst, mfb;
    int ma [3];

    always #5 clk = ~clk;

    rtc_calendar_core u0 (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .set_hold(set_hold),
        .bin_mode(bin_mode), .h24_mode(h24_mode), .dst_en(dst_en), .wr_en(wr_en),
        .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data), .alarm_hit(alarm_hit)
    );

    function automatic int enc(int v);
        return (mbin != 0) ? v : (((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int henc(int h, int pm);
        return (m24 != 0) ? enc(h) : ((pm != 0 ? 8'h80 : 0) | enc(h));
    endfunction

    function automatic int mdays(int mon, int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic int alarm_model();
        int nowb [3];
        int ok;
        nowb[0] = enc(ms); nowb[1] = enc(mm); nowb[2] = henc(mh, mpm);
        ok = 1;
        for (int i = 0; i < 3; i++)
            if (!(((ma[i] & 8'hC0) == 8'hC0) || (ma[i] == nowb[i]))) ok = 0;
        return ok;
    endfunction

    task automatic model_step();
        int dayc;
        int am1;
        dayc = 0;
        if (ms < 59) ms++;
        else begin
            ms = 0;
            if (mm < 59) mm++;
            else begin
                mm = 0;
                am1 = (mh == 1) && (m24 != 0 || mpm == 0);
                if (mdst != 0 && am1 != 0 && mdow == 1 && mmon == 4 && mdate <= 7) mh = 3;
                else if (mdst != 0 && am1 != 0 && mdow == 1 && mmon == 10 && mdate + 7 > 31 && mfb == 0) begin
                    mh = 1; mfb = 1;
                end else if (m24 != 0) begin
                    if (mh == 23) begin mh = 0; dayc = 1; end else mh++;
                end else begin
                    if (mh == 11) begin mh = 12; dayc = mpm; mpm = 1 - mpm; end
                    else if (mh == 12) mh = 1;
                    else mh++;
                end
            end
        end
        if (dayc != 0) begin
            mfb = 0;
            mdow = (mdow == 7) ? 1 : mdow + 1;
            if (mdate >= mdays(mmon, myr)) begin
                mdate = 1;
                if (mmon == 12) begin mmon = 1; myr = (myr == 99) ? 0 : myr + 1; end
                else mmon++;
            end else mdate++;
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output int v);
        reg_addr = a[3:0];
        #1;
        v = int'(rd_data);
    endtask

    task automatic check_time(input string req);
        int v;
        rd(0, v); chk(req, v, enc(ms));
        rd(2, v); chk(req, v, enc(mm));
        rd(4, v); chk(req, v, henc(mh, mpm));
        rd(6, v); chk(req, v, enc(mdow));
        rd(7, v); chk(req, v, enc(mdate));
        rd(8, v); chk(req, v, enc(mmon));
        rd(9, v); chk(req, v, enc(myr));
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_addr = a[3:0]; wr_data = d[7:0]; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // write the model time and alarms under hold, then release
    task automatic load_all();
        int ad [10];
        int dv [10];
        @(negedge clk);
        bin_mode = mbin[0]; h24_mode = m24[0]; dst_en = mdst[0];
        set_hold = 1'b1;
        ad = '{0, 2, 4, 6, 7, 8, 9, 1, 3, 5};
        dv = '{enc(ms), enc(mm), henc(mh, mpm), enc(mdow), enc(mdate), enc(mmon), enc(myr),
               ma[0], ma[1], ma[2]};
        for (int i = 0; i < 10; i++) begin
            reg_addr = ad[i][3:0]; wr_data = dv[i][7:0]; wr_en = 1'b1;
            @(negedge clk);
        end
        wr_en = 1'b0;
        set_hold = 1'b0;
        @(negedge clk);
        @(negedge clk);
        mfb = 0;
    endtask

    task automatic tick_once(input string req);
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        @(negedge clk);
        model_step();
        chk(req, int'(alarm_hit), alarm_model());
        @(negedge clk);
    endtask

    task automatic set_time(int s, int m, int h, int pm, int dw, int dt, int mo, int yr);
        ms = s; mm = m; mh = h; mpm = pm; mdow = dw; mdate = dt; mmon = mo; myr = yr;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got 0x0 expected 0x1 (run did not finish)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        void'($urandom(32'd1234));
        mbin = 0; m24 = 1; mdst = 0; mfb = 0;
        ma[0] = 0; ma[1] = 0; ma[2] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(0, v); chk("R1", v, 8'h00);
        rd(2, v); chk("R1", v, 8'h00);
        rd(4, v); chk("R1", v, 8'h00);
        rd(6, v); chk("R1", v, 8'h01);
        rd(7, v); chk("R1", v, 8'h01);
        rd(8, v); chk("R1", v, 8'h01);
        rd(9, v); chk("R1", v, 8'h00);
        rd(5, v); chk("R1", v, 8'h00);
        chk("R1", int'(alarm_hit), 0);
        // R13: unused address
        rd(12, v); chk("R13", v, 8'h00);
        rd(15, v); chk("R13", v, 8'h00);

        // R3 R5: BCD 24h end of century
        mbin = 0; m24 = 1; mdst = 0;
        ma = '{8'h00, 8'h00, 8'h00};
        set_time(59, 59, 23, 0, 7, 31, 12, 99);
        load_all();
        tick_once("R10");
        rd(0, v); chk("R3", v, 8'h00);
        rd(4, v); chk("R3", v, 8'h00);
        rd(6, v); chk("R5", v, 8'h01);
        rd(7, v); chk("R5", v, 8'h01);
        rd(8, v); chk("R5", v, 8'h01);
        rd(9, v); chk("R5", v, 8'h00);

        // R2: binary seconds wrap
        mbin = 1; m24 = 1;
        set_time(59, 14, 5, 0, 3, 10, 6, 30);
        load_all();
        rd(0, v); chk("R2", v, 8'h3B);
        tick_once("R2");
        rd(0, v); chk("R2", v, 8'h00);
        rd(2, v); chk("R2", v, 8'h0F);

        // R4: 12-hour transitions, BCD
        mbin = 0; m24 = 0;
        set_time(59, 59, 11, 0, 2, 14, 3, 21);
        load_all();
        tick_once("R4");
        rd(4, v); chk("R4", v, 8'h92);
        rd(7, v); chk("R4", v, 8'h14);
        set_time(59, 59, 12, 1, 2, 14, 3, 21);
        load_all();
        tick_once("R4");
        rd(4, v); chk("R4", v, 8'h81);
        set_time(59, 59, 11, 1, 2, 14, 3, 21);
        load_all();
        tick_once("R4");
        rd(4, v); chk("R4", v, 8'h12);
        rd(7, v); chk("R4", v, 8'h15);
        rd(6, v); chk("R4", v, 8'h03);
        // R4: binary noon
        mbin = 1;
        set_time(59, 59, 11, 0, 2, 14, 3, 21);
        load_all();
        tick_once("R4");
        rd(4, v); chk("R4", v, 8'h8C);

        // R5: month lengths and leap years
        mbin = 0; m24 = 1;
        set_time(59, 59, 23, 0, 1, 28, 2, 24);
        load_all(); tick_once("R5");
        rd(7, v); chk("R5", v, 8'h29);
        set_time(59, 59, 23, 0, 1, 28, 2, 23);
        load_all(); tick_once("R5");
        rd(7, v); chk("R5", v, 8'h01);
        rd(8, v); chk("R5", v, 8'h03);
        set_time(59, 59, 23, 0, 1, 30, 4, 23);
        load_all(); tick_once("R5");
        rd(8, v); chk("R5", v, 8'h05);

        // R8: spring forward, and no jump when disabled
        mdst = 1;
        set_time(59, 59, 1, 0, 1, 5, 4, 26);
        load_all(); tick_once("R8");
        rd(4, v); chk("R8", v, 8'h03);
        rd(2, v); chk("R8", v, 8'h00);
        mdst = 0;
        set_time(59, 59, 1, 0, 1, 5, 4, 26);
        load_all(); tick_once("R8");
        rd(4, v); chk("R8", v, 8'h02);

        // R9: fall back once
        mdst = 1;
        ma = '{8'h00, 8'h00, 8'h07};
        set_time(59, 59, 1, 0, 1, 28, 10, 23);
        load_all(); tick_once("R9");
        rd(4, v); chk("R9", v, 8'h01);
        rd(0, v); chk("R9", v, 8'h00);
        for (int i = 0; i < 3600; i++) tick_once("R9");
        rd(4, v); chk("R9", v, 8'h02);
        rd(2, v); chk("R9", v, 8'h00);
        check_time("R9");
        mdst = 0;

        // R10 R11: alarm compare
        mbin = 0; m24 = 1;
        ma = '{8'h05, 8'h10, 8'h08};
        set_time(4, 10, 8, 0, 4, 9, 9, 9);
        load_all();
        tick_once("R10");
        chk("R10", alarm_model(), 1);
        tick_once("R10");
        chk("R10", alarm_model(), 0);
        ma = '{8'hFF, 8'hC3, 8'hE0};
        load_all();
        for (int i = 0; i < 3; i++) tick_once("R11");
        ma = '{8'h30, 8'hC0, 8'hC0};
        set_time(28, 1, 2, 0, 4, 9, 9, 9);
        load_all();
        tick_once("R11");
        tick_once("R11");
        chk("R11", alarm_model(), 1);

        // R6: time write ignored without hold
        wr(0, 8'h33);
        rd(0, v); chk("R6", v, enc(ms));
        // R10: alarm write accepted without hold
        wr(1, 8'h45);
        rd(1, v); chk("R10", v, 8'h45);
        ma[0] = 8'h45;

        // R6 R7: freeze while the live copy keeps counting
        ma = '{8'h32, 8'h20, 8'h10};
        set_time(30, 20, 10, 0, 5, 11, 11, 11);
        load_all();
        @(negedge clk);
        set_hold = 1'b1;
        for (int i = 0; i < 3; i++) tick_once("R6");
        rd(0, v); chk("R6", v, 8'h30);
        rd(2, v); chk("R6", v, 8'h20);
        @(negedge clk);
        set_hold = 1'b0;
        @(negedge clk);
        @(negedge clk);
        ms = 30; mfb = 0;
        check_time("R7");
        tick_once("R7");
        rd(0, v); chk("R7", v, 8'h31);

        // R12: randomized coverage of carries with both encodings and formats
        for (int it = 0; it < 40; it++) begin
            int n;
            mbin = int'($urandom % 2);
            m24  = int'($urandom % 2);
            mdst = int'($urandom % 2);
            mmon = 1 + int'($urandom % 12);
            myr  = int'($urandom % 100);
            mdate = ($urandom % 2 != 0) ? mdays(mmon, myr) : 1 + int'($urandom % mdays(mmon, myr));
            mdow = 1 + int'($urandom % 7);
            if (m24 != 0) begin mh = int'($urandom % 24); mpm = 0; end
            else begin mh = 1 + int'($urandom % 12); mpm = int'($urandom % 2); end
            mm = 58 + int'($urandom % 2);
            ms = 56 + int'($urandom % 4);
            ma[0] = ($urandom % 2 != 0) ? 8'hC0 : enc(59);
            ma[1] = ($urandom % 2 != 0) ? 8'hFF : enc(mm);
            ma[2] = 8'hD5;
            load_all();
            n = 1 + int'($urandom % 5);
            for (int k = 0; k < n; k++) begin
                tick_once("R12");
                check_time("R12");
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule